// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four incoming handshake lines of a serial port (clear to send, data set ready, ring indicator and carrier detect) and presents them as one status byte. The upper nibble gives the present level of each line. The lower nibble holds one sticky change flag per line. A flag stays set until software reads the status byte, and an interrupt request is raised while any flag is set and the modem-status interrupt is enabled.

Three of the lines flag a change in either direction. The ring indicator flags only a transition from inactive to active. Each external line passes through a two-stage synchroniser before any change is detected. When the loopback bit of the modem-control input is set, the four modem-control outputs take the place of the external lines. This lets software test the change logic without anything attached. After reset the level nibble is loaded from the lines as they stand, and no flag is raised for that initial load.

Top module: `modem_status_tracker`

## Requirements
- R1: status_o[7:4] show the current levels, from bit 7 down to bit 4: carrier detect, ring indicator, data set ready, clear to send. On lines_i these are lines_i[3], lines_i[2], lines_i[1] and lines_i[0].
- R2: status_o[0] (clear to send), status_o[1] (data set ready) and status_o[3] (carrier detect) become 1 when the matching line changes level in either direction.
- R3: status_o[2] becomes 1 only when the ring indicator goes from 0 to 1. A 1-to-0 transition leaves the bit unchanged.
- R4: Change flags accumulate until a read. On the rising edge that ends a cycle with rd_i high, all flags clear, except that a change detected on that same edge still sets its flag.
- R5: With mcr_i[4] high (loopback), the external lines are ignored. In their place, mcr_i[1] drives clear to send, mcr_i[0] drives data set ready, mcr_i[2] drives ring indicator and mcr_i[3] drives carrier detect.
- R6: irq_o is high exactly when msi_en_i is high and at least one of status_o[3:0] is set.
- R7: After reset is released, the level nibble settles to the line levels present at the time, with all flags 0 and irq_o low.
- R8: A change on lines_i shows in status_o on the third rising edge after it. A change on mcr_i in loopback shows on the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | 4 | Asynchronous modem lines: [0] clear to send, [1] data set ready, [2] ring indicator, [3] carrier detect |
| mcr_i | input | 5 | Modem control: [0] DTR, [1] RTS, [2] OUT1, [3] OUT2, [4] loopback |
| rd_i | input | 1 | Status read strobe, one cycle per read |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| status_o | output | 8 | Levels in [7:4], sticky change flags in [3:0] |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The bench targets five corner cases:
- A falling ring indicator. A design that treated the ring line like the others would raise bit 2 here.
- A read that lands on the same edge as a new change. A design that gave the clear priority would lose that event.
- Line activity while loopback is on. A design with a leaky selector would report it.
- The release of reset with lines already active. A design that did not prime its levels would raise spurious flags.
- Latency counted edge by edge. A missing or extra synchroniser stage would show up as a shifted update.

// File: rtl/mst_pkg.sv
`timescale 1ns/1ps
package mst_pkg;
  localparam int unsigned NUM_LINES    = 4;
  localparam int unsigned MCR_W        = 5;
  localparam int unsigned MCR_LOOP_BIT = 4;

  // line index == flag bit index == (level bit index - NUM_LINES)
  localparam int unsigned LN_CTS = 0;
  localparam int unsigned LN_DSR = 1;
  localparam int unsigned LN_RI  = 2;
  localparam int unsigned LN_DCD = 3;

  localparam int unsigned MCR_DTR  = 0;
  localparam int unsigned MCR_RTS  = 1;
  localparam int unsigned MCR_OUT1 = 2;
  localparam int unsigned MCR_OUT2 = 3;

  function automatic logic [NUM_LINES-1:0] loop_map(input logic [MCR_W-1:0] mcr);
    logic [NUM_LINES-1:0] v;
    v         = '0;
    v[LN_CTS] = mcr[MCR_RTS];
    v[LN_DSR] = mcr[MCR_DTR];
    v[LN_RI]  = mcr[MCR_OUT1];
    v[LN_DCD] = mcr[MCR_OUT2];
    return v;
  endfunction
endpackage

// File: rtl/mst_sync.sv
`timescale 1ns/1ps
module mst_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mst_src_sel.sv
`timescale 1ns/1ps
module mst_src_sel
  import mst_pkg::*;
(
  input  logic [NUM_LINES-1:0] ext_i,
  input  logic [MCR_W-1:0]     mcr_i,
  output logic [NUM_LINES-1:0] sel_o
);
  always_comb begin
    if (mcr_i[MCR_LOOP_BIT]) sel_o = loop_map(mcr_i);
    else                     sel_o = ext_i;
  end
endmodule

// File: rtl/mst_delta_core.sv
`timescale 1ns/1ps
module mst_delta_core #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned RING_IDX  = 2,
  parameter int unsigned PRIME_CYC = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 rd_i,
  output logic [NUM_LINES-1:0] level_o,
  output logic [NUM_LINES-1:0] delta_o
);
  localparam int unsigned CNT_W = $clog2(PRIME_CYC + 1);
  localparam logic [CNT_W-1:0] PRIME_END = CNT_W'(PRIME_CYC);

  logic [CNT_W-1:0]     prime_q;
  logic                 priming;
  logic [NUM_LINES-1:0] level_q, delta_q, hit;

  assign priming = (prime_q != PRIME_END);

  // levels follow the inputs without flags until the synchroniser holds real data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prime_q <= '0;
    else if (priming) prime_q <= prime_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_det
    if (i == RING_IDX) begin : g_rise
      assign hit[i] = line_i[i] & ~level_q[i];
    end else begin : g_any
      assign hit[i] = line_i[i] ^ level_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      delta_q <= '0;
    end else begin
      level_q <= line_i;
      if (priming) delta_q <= '0;
      else         delta_q <= (rd_i ? '0 : delta_q) | hit;
    end
  end

  assign level_o = level_q;
  assign delta_o = delta_q;
endmodule

// File: rtl/modem_status_tracker.sv
`timescale 1ns/1ps
module modem_status_tracker
  import mst_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_LINES-1:0]   lines_i,
  input  logic [MCR_W-1:0]       mcr_i,
  input  logic                   rd_i,
  input  logic                   msi_en_i,
  output logic [2*NUM_LINES-1:0] status_o,
  output logic                   irq_o
);
  localparam int unsigned PRIME_CYC = SYNC_STAGES + 1;

  logic [NUM_LINES-1:0] ext_sync, line_sel, level, delta;

  mst_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (lines_i),
    .q_o    (ext_sync)
  );

  mst_src_sel u_sel (
    .ext_i (ext_sync),
    .mcr_i (mcr_i),
    .sel_o (line_sel)
  );

  mst_delta_core #(
    .NUM_LINES (NUM_LINES),
    .RING_IDX  (LN_RI),
    .PRIME_CYC (PRIME_CYC)
  ) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_sel),
    .rd_i    (rd_i),
    .level_o (level),
    .delta_o (delta)
  );

  assign status_o = {level, delta};
  assign irq_o    = msi_en_i & (|delta);
endmodule

// File: rtl/mst_checker.sv
`timescale 1ns/1ps
module mst_checker #(
  parameter int unsigned SETTLE = 5
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] mcr_i,
  input logic       rd_i,
  input logic       msi_en_i,
  input logic [7:0] status_o,
  input logic       irq_o
);
  logic [7:0] cnt_q;
  logic       settled;
  assign settled = (cnt_q == 8'(SETTLE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!settled) cnt_q <= cnt_q + 8'd1;
  end

  assert_cts_delta_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && !$stable(status_o[4])) |-> status_o[0]);
  assert_dcd_delta_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && !$stable(status_o[7])) |-> status_o[3]);
  assert_ring_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && $rose(status_o[2])) |-> $rose(status_o[6]));
  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && !rd_i) |=> ((status_o[3:0] & $past(status_o[3:0])) == $past(status_o[3:0])));
  assert_loop_map_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && mcr_i[4]) |=>
      (status_o[7:4] == {$past(mcr_i[3]), $past(mcr_i[2]), $past(mcr_i[0]), $past(mcr_i[1])}));
  assert_irq_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msi_en_i |-> !irq_o);
  assert_irq_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o[3:0] != 4'b0));
endmodule

bind modem_status_tracker mst_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mcr_i    (mcr_i),
  .rd_i     (rd_i),
  .msi_en_i (msi_en_i),
  .status_o (status_o),
  .irq_o    (irq_o)
);

// File: tb/modem_status_tracker_test.sv
`timescale 1ns/1ps
module modem_status_tracker_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] lines;
  logic [4:0] mcr;
  logic       rd;
  logic       en;
  wire  [7:0] status;
  wire        irq;

  always #2 clk = ~clk;

  modem_status_tracker uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .lines_i  (lines),
    .mcr_i    (mcr),
    .rd_i     (rd),
    .msi_en_i (en),
    .status_o (status),
    .irq_o    (irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [3:0] m_lvl, m_dlt;

  function automatic logic [3:0] f_loop(input logic [4:0] m);
    return {m[3], m[2], m[0], m[1]};
  endfunction

  function automatic logic [3:0] f_detect(input logic [3:0] o, input logic [3:0] n);
    logic [3:0] d;
    d    = o ^ n;
    d[2] = n[2] & ~o[2];
    return d;
  endfunction

  function automatic logic [3:0] f_eff(input logic [4:0] m, input logic [3:0] l);
    return m[4] ? f_loop(m) : l;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, status, {m_lvl, m_dlt});
    check({req, " irq R6"}, {7'b0, irq}, {7'b0, en & (|m_dlt)});
  endtask

  task automatic settle(input string req);
    logic [3:0] nw;
    repeat (4) @(negedge clk);
    nw = f_eff(mcr, lines);
    m_dlt |= f_detect(m_lvl, nw);
    m_lvl = nw;
    check_all(req);
  endtask

  task automatic do_read(input string req);
    @(negedge clk);
    rd = 1'b1;
    check({req, " read value"}, status, {m_lvl, m_dlt});
    @(negedge clk);
    rd = 1'b0;
    m_dlt = '0;
    check_all(req);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] old_lvl, nw;
    int unsigned seed_val;
    seed_val = $urandom(32'h00c0ffee);
    rst_n = 1'b0; lines = 4'b1010; mcr = '0; rd = 1'b0; en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_lvl = lines; m_dlt = '0;
    repeat (5) @(negedge clk);
    check_all("R7 reset prime");

    // R8 external latency, R2 clear-to-send rise, R1 level mapping
    lines = 4'b1011;
    @(negedge clk); check("R8 edge1", status, {m_lvl, m_dlt});
    @(negedge clk); check("R8 edge2", status, {m_lvl, m_dlt});
    @(negedge clk);
    m_dlt |= f_detect(m_lvl, lines); m_lvl = lines;
    check_all("R8 edge3 R2 R1");

    en = 1'b1;
    @(negedge clk); check_all("R6 enable");
    do_read("R4 clear");

    // R3 ring rise and fall
    lines = 4'b1111; settle("R3 ring rise");
    do_read("R4");
    lines = 4'b1011; settle("R3 ring fall ignored");
    lines = 4'b0011; settle("R2 carrier fall");
    do_read("R4");

    // R4 change detected on the same edge as the read clear
    lines = 4'b0010; settle("R2 cts fall");
    old_lvl = m_lvl;
    lines = 4'b0000;
    @(negedge clk); @(negedge clk);
    rd = 1'b1;
    check("R4 concurrent read value", status, {m_lvl, m_dlt});
    @(negedge clk);
    rd = 1'b0;
    m_dlt = f_detect(old_lvl, lines); m_lvl = lines;
    check_all("R4 concurrent set wins");
    do_read("R4");

    // R5 loopback, R8 loopback latency
    mcr = 5'b10101;
    @(negedge clk);
    nw = f_loop(mcr); m_dlt |= f_detect(m_lvl, nw); m_lvl = nw;
    check_all("R8 loopback latency R5");
    lines = 4'b1111; settle("R5 external ignored");
    do_read("R5");
    mcr = 5'b11010; settle("R5 mapping");
    mcr = 5'b00000; settle("R5 loopback off");
    do_read("R4");

    // random mix
    for (int k = 0; k < 300; k++) begin
      int unsigned op;
      op = $urandom % 10;
      if (op < 5) begin
        lines = 4'($urandom);
        settle("R1 R2 R3 random lines");
      end else if (op < 7) begin
        mcr = 5'($urandom);
        if (($urandom % 3) != 0) mcr[4] = 1'b0;
        settle("R5 random mcr");
      end else if (op < 9) begin
        do_read("R4 random read");
      end else begin
        en = ~en;
        @(negedge clk);
        check_all("R6 random enable");
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule